// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide, two-address register front end of an eight-line priority interrupt controller. A host writes bytes into it to run a short setup sequence. That sequence sets the vector base, the single-controller flag and the mode options. After setup, further writes load the line mask, choose what address 0 reads back, arm a poll, turn special masking on or off, and issue end-of-service or rotation commands. The block holds the request, in-service and mask registers and the rotation base. Three instances of a rotating priority resolver decide which line is offered to the processor and which in-service line a non-specific end-of-service command retires.

The processor side sees a level `int_out` and an acknowledge strobe. During the acknowledge cycle `ack_vec` carries the vector, and the edge at the end of that cycle updates the in-service state, the request state and, with automatic end-of-service, the rotation base. Requests are latched on rising edges of the request pins. A poll read gives the same winner as an acknowledge but as a plain line number, and it retires the line at once.

Top module: `intc_cmd_unit`

## Requirements
- R1: After reset the mask, request and in-service registers read 0, `int_out` is low, address 0 returns the request register, and the rotation base is line 0 (line 0 has the highest priority).
- R2: A write to address 0 with bit 4 set clears every register and flag, starts setup at the base step, takes bit 0 as "fourth word follows" and bit 1 as "single controller", and `int_out` is low in the cycle after it.
- R3: In the base step, an address-1 write sets the vector base to the byte with bits 2:0 forced to 0. The next step is the cascade word when not single. When single, the next step is the option word if a fourth word follows, and setup ends if not. A cascade-word write moves to the option word if a fourth word follows and ends setup if not.
- R4: An option-word write takes bit 4 as nested mode and bit 1 as automatic end-of-service, then ends setup.
- R5: Outside setup, an address-1 write loads the mask, which address 1 reads back. A request on a masked line is not offered.
- R6: An address-0 write with bit 4 clear and bit 3 set arms a poll if bit 2 is set. If bit 1 is set, bit 0 chooses in-service (1) or request (0) for address-0 reads. If bit 6 is set, bit 5 sets special masking. Special masking leaves masked in-service lines out of the blocking priority.
- R7: Priority order runs upward from the rotation base and wraps. An unmasked request is offered only when it outranks every in-service line.
- R8: An address-0 write with bits 4 and 3 clear and bits 7:5 = 1 retires the highest-priority in-service line. Code 5 does the same and also moves the rotation base to that line plus 1.
- R9: Code 3 retires the in-service line named in bits 2:0. Code 6 sets the rotation base to bits 2:0 plus 1. Code 7 retires the named line and sets the base to it plus 1. Code 2 changes nothing.
- R10: Codes 0 and 4 set rotate-on-automatic-end-of-service to bit 7. With automatic end-of-service on, an acknowledge leaves the in-service register as it is, and if rotation is on it moves the base to the acknowledged line plus 1.
- R11: During an acknowledge, `ack_vec` is the vector base OR the winning line, or the base OR 7 when nothing is offered. In normal mode the acknowledge sets the line's in-service bit and clears its request bit.
- R12: A read with a poll armed returns the winning line, or 7 if there is none, clears that line's request and in-service bits, and disarms the poll.
- R13: A request bit is set only on a 0-to-1 transition of its pin. A pin held high does not set it again after it has been cleared.
- R14: With nested mode on and single mode off, the in-service bit of the cascade line (line 2) does not block a new request on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request pins, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| ack_en | input | 1 | Processor interrupt acknowledge strobe |
| addr | input | 1 | Register address (bit 0 of the host address) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid while rd_en is high |
| ack_vec | output | 8 | Vector byte, valid while ack_en is high |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that no more than one of write, read and acknowledge is high in any cycle. An input check guards this, and the bench drives every access as a single-cycle strobe from a task, so no two accesses overlap. The checks also assume the request pins change only between accesses. The bench changes them in a separate step and then waits two cycles so the edge latch settles before the next strobe. Because of this, no check depends on how a new edge and a same-cycle clear combine.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // setup progress; encoding order matters only for readability
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_BASE = 2'd1,
      ST_CASC = 2'd2,
      ST_OPT  = 2'd3
   } init_step_e;

   // operation code held in bits 7:5 of an address-0 command byte
   typedef enum logic [2:0] {
      OP_AROT_A  = 3'd0,
      OP_EOI_HI  = 3'd1,
      OP_NONE    = 3'd2,
      OP_EOI_SEL = 3'd3,
      OP_AROT_B  = 3'd4,
      OP_EOI_ROT = 3'd5,
      OP_SET_ROT = 3'd6,
      OP_SEL_ROT = 3'd7
   } opcmd_e;

   typedef struct packed {
      logic need_w4;
      logic solo;
      logic nested;
      logic auto_eoi;
      logic rot_aeoi;
      logic spec_mask;
      logic sel_isr;
      logic poll_pend;
   } mode_flags_t;

endpackage

// File: rtl/intc_prio_res.sv
module intc_prio_res #(
   parameter int LINES  = 8,
   parameter int LINE_W = $clog2(LINES),
   parameter int IMPL   = 0
) (
   input  logic [LINES-1:0]  vec,
   input  logic [LINE_W-1:0] base,
   output logic              found,
   output logic [LINE_W-1:0] line,
   output logic [LINE_W:0]   rank
);

   localparam logic [LINE_W:0] NO_RANK = (LINE_W+1)'(LINES);

   if (LINES != (1 << LINE_W)) begin : g_bad_lines
      $error("intc_prio_res: LINES must be a power of two matching LINE_W");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("intc_prio_res: IMPL must be 0 or 1");
   end

   generate
      if (IMPL == 0) begin : g_rotate
         // barrel-rotate first, then a fixed lowest-index scan
         logic [LINES-1:0] rot;
         assign rot = LINES'({vec, vec} >> base);

         always_comb begin
            found = 1'b0;
            rank  = NO_RANK;
            for (int p = LINES - 1; p >= 0; p--) begin
               if (rot[p]) begin
                  found = 1'b1;
                  rank  = (LINE_W+1)'(p);
               end
            end
            line = rank[LINE_W-1:0] + base;
         end
      end else begin : g_scan
         // walk priority levels, mapping each to its line by modular add
         always_comb begin
            found = 1'b0;
            rank  = NO_RANK;
            line  = base;
            for (int p = LINES - 1; p >= 0; p--) begin
               if (vec[LINE_W'(p) + base]) begin
                  found = 1'b1;
                  rank  = (LINE_W+1)'(p);
                  line  = LINE_W'(p) + base;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_in,
   input  logic             clr_all,
   input  logic [LINES-1:0] clr_mask,
   output logic [LINES-1:0] irr_q
);

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] rise;

   assign rise = req_in & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q  <= '0;
         prev_q <= '0;
      end else if (clr_all) begin
         irr_q  <= '0;
         prev_q <= '0;
      end else begin
         irr_q  <= (irr_q & ~clr_mask) | rise;
         prev_q <= req_in;
      end
   end

   // R13
   irr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all && clr_mask == '0) |=> ((irr_q & $past(irr_q)) == $past(irr_q)));

   // R13
   irr_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all && clr_mask == '0 && irr_q == '0 && req_in == prev_q) |=> (irr_q == '0));

endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
   import intc_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int LINE_W = $clog2(LINES),
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              ack_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              win_found,
   input  logic [LINE_W-1:0] win_line,
   input  logic              svc_found,
   input  logic [LINE_W-1:0] svc_line,
   output logic [LINES-1:0]  imr_q,
   output logic [LINES-1:0]  isr_q,
   output logic [LINE_W-1:0] rot_base_q,
   output logic [DATA_W-1:0] vbase_q,
   output mode_flags_t       mode_q,
   output logic [LINES-1:0]  irr_clr,
   output logic              init_clr
);

   localparam logic [DATA_W-1:0] LINE_FIELD = DATA_W'(LINES - 1);
   localparam logic [LINE_W-1:0] ONE_LINE   = LINE_W'(1);

   init_step_e step_q;

   logic is_dw;
   logic is_mode_cmd;
   logic is_op_cmd;
   logic poll_rd;
   logic ack_hit;
   logic [LINE_W-1:0] sel_line;
   opcmd_e op;

   assign init_clr    = wr_en && !addr && wr_data[4];
   assign is_dw       = wr_en && addr;
   assign is_mode_cmd = wr_en && !addr && !wr_data[4] && wr_data[3];
   assign is_op_cmd   = wr_en && !addr && !wr_data[4] && !wr_data[3];
   assign poll_rd     = rd_en && mode_q.poll_pend;
   assign ack_hit     = ack_en && win_found;
   assign sel_line    = wr_data[LINE_W-1:0];
   assign op          = opcmd_e'(wr_data[7:5]);

   // request bits retired by an acknowledge or a poll read
   always_comb begin
      irr_clr = '0;
      if ((ack_hit || (poll_rd && win_found)) && !init_clr) begin
         irr_clr = LINES'(1) << win_line;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init_clr) begin
         imr_q      <= '0;
         isr_q      <= '0;
         rot_base_q <= '0;
         vbase_q    <= '0;
         mode_q     <= '0;
         step_q     <= ST_RUN;
         if (rst_n) begin
            step_q         <= ST_BASE;
            mode_q.need_w4 <= wr_data[0];
            mode_q.solo    <= wr_data[1];
         end
      end else begin
         if (is_dw) begin
            unique case (step_q)
               ST_RUN: imr_q <= wr_data[LINES-1:0];
               ST_BASE: begin
                  vbase_q <= wr_data & ~LINE_FIELD;
                  if (!mode_q.solo) begin
                     step_q <= ST_CASC;
                  end else begin
                     step_q <= mode_q.need_w4 ? ST_OPT : ST_RUN;
                  end
               end
               ST_CASC: step_q <= mode_q.need_w4 ? ST_OPT : ST_RUN;
               ST_OPT: begin
                  mode_q.nested   <= wr_data[4];
                  mode_q.auto_eoi <= wr_data[1];
                  step_q          <= ST_RUN;
               end
               default: step_q <= ST_RUN;
            endcase
         end

         if (is_mode_cmd) begin
            if (wr_data[2]) mode_q.poll_pend <= 1'b1;
            if (wr_data[1]) mode_q.sel_isr   <= wr_data[0];
            if (wr_data[6]) mode_q.spec_mask <= wr_data[5];
         end

         if (is_op_cmd) begin
            unique case (op)
               OP_AROT_A, OP_AROT_B: mode_q.rot_aeoi <= wr_data[7];
               OP_EOI_HI: begin
                  if (svc_found) isr_q[svc_line] <= 1'b0;
               end
               OP_EOI_ROT: begin
                  if (svc_found) begin
                     isr_q[svc_line] <= 1'b0;
                     rot_base_q      <= svc_line + ONE_LINE;
                  end
               end
               OP_EOI_SEL: isr_q[sel_line] <= 1'b0;
               OP_SET_ROT: rot_base_q <= sel_line + ONE_LINE;
               OP_SEL_ROT: begin
                  isr_q[sel_line] <= 1'b0;
                  rot_base_q      <= sel_line + ONE_LINE;
               end
               OP_NONE: ;
               default: ;
            endcase
         end

         if (ack_hit) begin
            if (mode_q.auto_eoi) begin
               if (mode_q.rot_aeoi) rot_base_q <= win_line + ONE_LINE;
            end else begin
               isr_q[win_line] <= 1'b1;
            end
         end

         if (poll_rd) begin
            mode_q.poll_pend <= 1'b0;
            if (win_found) isr_q[win_line] <= 1'b0;
         end
      end
   end

   // R2
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_clr |=> (isr_q == '0 && imr_q == '0 && rot_base_q == '0 && step_q == ST_BASE));

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dw && step_q == ST_RUN) |=> (imr_q == $past(wr_data[LINES-1:0])));

   // R9
   eoi_named_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_op_cmd && op == OP_EOI_SEL) |=> !isr_q[$past(sel_line)]);

   // R12
   poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_rd |=> !mode_q.poll_pend);

   // R10
   aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && mode_q.auto_eoi && !init_clr) |=> $stable(isr_q));

   // R3
   vbase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dw && step_q == ST_BASE) |=> (vbase_q[LINE_W-1:0] == '0 &&
         vbase_q[DATA_W-1:LINE_W] == $past(wr_data[DATA_W-1:LINE_W])));

endmodule

// File: rtl/intc_cmd_unit.sv
module intc_cmd_unit
   import intc_pkg::*;
#(
   parameter int LINES     = 8,
   parameter int DATA_W    = 8,
   parameter int CASC_LINE = 2,
   parameter int SPUR_LINE = 7,
   parameter int RES_IMPL  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  req_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              ack_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ack_vec,
   output logic              int_out
);

   localparam int LINE_W = $clog2(LINES);
   localparam logic [LINES-1:0]  CASC_BIT = LINES'(1) << CASC_LINE;
   localparam logic [LINE_W-1:0] SPUR     = LINE_W'(SPUR_LINE);

   if (DATA_W != 8 || LINES != 8) begin : g_bad_width
      $error("intc_cmd_unit: command field layout needs 8 lines and 8-bit data");
   end
   if (CASC_LINE < 0 || CASC_LINE >= LINES || SPUR_LINE < 0 || SPUR_LINE >= LINES) begin : g_bad_line
      $error("intc_cmd_unit: CASC_LINE and SPUR_LINE must name a line");
   end

   logic [LINES-1:0]  irr_q, imr_q, isr_q, irr_clr;
   logic [LINE_W-1:0] rot_base_q;
   logic [DATA_W-1:0] vbase_q;
   mode_flags_t       mode_q;
   logic              init_clr;

   logic [LINES-1:0]  pend_vec, block_vec;
   logic              pend_found, block_found, svc_found;
   logic [LINE_W-1:0] pend_line, block_line, svc_line;
   logic [LINE_W:0]   pend_rank, block_rank, svc_rank;
   logic              win_found;
   logic [LINE_W-1:0] out_line;

   intc_req_latch #(.LINES(LINES)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_in   (req_in),
      .clr_all  (init_clr),
      .clr_mask (irr_clr),
      .irr_q    (irr_q)
   );

   assign pend_vec  = irr_q & ~imr_q;
   assign block_vec = isr_q
                    & (mode_q.spec_mask ? ~imr_q : '1)
                    & ((mode_q.nested && !mode_q.solo) ? ~CASC_BIT : '1);

   intc_prio_res #(.LINES(LINES), .LINE_W(LINE_W), .IMPL(RES_IMPL)) u_pend (
      .vec (pend_vec), .base (rot_base_q),
      .found (pend_found), .line (pend_line), .rank (pend_rank)
   );

   intc_prio_res #(.LINES(LINES), .LINE_W(LINE_W), .IMPL(RES_IMPL)) u_block (
      .vec (block_vec), .base (rot_base_q),
      .found (block_found), .line (block_line), .rank (block_rank)
   );

   intc_prio_res #(.LINES(LINES), .LINE_W(LINE_W), .IMPL(RES_IMPL)) u_svc (
      .vec (isr_q), .base (rot_base_q),
      .found (svc_found), .line (svc_line), .rank (svc_rank)
   );

   // an empty blocking set ranks at LINES, below every real level
   assign win_found = pend_found && (pend_rank < block_rank);
   assign out_line  = win_found ? pend_line : SPUR;

   intc_ctrl_regs #(.LINES(LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .ack_en     (ack_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .win_found  (win_found),
      .win_line   (pend_line),
      .svc_found  (svc_found),
      .svc_line   (svc_line),
      .imr_q      (imr_q),
      .isr_q      (isr_q),
      .rot_base_q (rot_base_q),
      .vbase_q    (vbase_q),
      .mode_q     (mode_q),
      .irr_clr    (irr_clr),
      .init_clr   (init_clr)
   );

   always_comb begin
      if (mode_q.poll_pend) begin
         rd_data = DATA_W'(out_line);
      end else if (addr) begin
         rd_data = DATA_W'(imr_q);
      end else begin
         rd_data = DATA_W'(mode_q.sel_isr ? isr_q : irr_q);
      end
   end

   assign ack_vec = vbase_q | DATA_W'(out_line);
   assign int_out = win_found;

   // R11 strobes are exclusive
   one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, rd_en, ack_en}));

   // R2
   int_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wr_data[4]) |=> !int_out);

   // R7
   blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_found && pend_found && block_rank <= pend_rank) |-> !int_out);

   // R8
   svc_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.spec_mask && !(mode_q.nested && !mode_q.solo)) |-> (svc_rank == block_rank));

   logic unused_ok;
   assign unused_ok = &{1'b0, block_line};

endmodule

// File: tb/sim_intc_cmd_unit.sv
`timescale 1ns/1ps
module sim_intc_cmd_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = 8'h00;
   logic       wr_en = 1'b0, rd_en = 1'b0, ack_en = 1'b0, addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data, ack_vec;
   logic       int_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string tag = "R7 idle";

   always #5 clk = ~clk;

   intc_cmd_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en), .rd_en(rd_en),
      .ack_en(ack_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .ack_vec(ack_vec), .int_out(int_out)
   );

   // behavioural reference state
   logic [7:0] m_irr, m_prev, m_imr, m_isr, m_base;
   int m_pb, m_step;
   bit m_f4, m_single, m_nested, m_aeoi, m_rot, m_smm, m_rsel, m_poll;
   int mw, mp, ml;
   logic [7:0] edges;
   bit initw;

   function automatic int best(logic [7:0] v, int pb);
      for (int p = 0; p < 8; p++) if (v[(p + pb) % 8]) return p;
      return 8;
   endfunction

   function automatic int m_win();
      logic [7:0] cm;
      int p, c;
      p = best(m_irr & ~m_imr, m_pb);
      if (p == 8) return -1;
      cm = m_isr;
      if (m_smm) cm = cm & ~m_imr;
      if (m_nested && !m_single) cm[2] = 1'b0;
      c = best(cm, m_pb);
      if (p < c) return (p + m_pb) % 8;
      return -1;
   endfunction

   task automatic m_clear();
      m_irr = 0; m_prev = 0; m_imr = 0; m_isr = 0; m_base = 0; m_pb = 0; m_step = 0;
      m_f4 = 0; m_single = 0; m_nested = 0; m_aeoi = 0; m_rot = 0; m_smm = 0;
      m_rsel = 0; m_poll = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_clear();
      end else begin
         mw = m_win();
         edges = req_in & ~m_prev;
         initw = 1'b0;
         if (wr_en && !addr && wr_data[4]) begin
            m_clear();
            m_step = 1; m_f4 = wr_data[0]; m_single = wr_data[1];
            initw = 1'b1;
         end else if (wr_en && addr) begin
            case (m_step)
               0: m_imr = wr_data;
               1: begin
                  m_base = wr_data & 8'hF8;
                  m_step = !m_single ? 2 : (m_f4 ? 3 : 0);
               end
               2: m_step = m_f4 ? 3 : 0;
               default: begin
                  m_nested = wr_data[4]; m_aeoi = wr_data[1]; m_step = 0;
               end
            endcase
         end else if (wr_en && wr_data[3]) begin
            if (wr_data[2]) m_poll = 1;
            if (wr_data[1]) m_rsel = wr_data[0];
            if (wr_data[6]) m_smm = wr_data[5];
         end else if (wr_en) begin
            case (wr_data[7:5])
               3'd0, 3'd4: m_rot = wr_data[7];
               3'd1, 3'd5: begin
                  mp = best(m_isr, m_pb);
                  if (mp < 8) begin
                     ml = (mp + m_pb) % 8;
                     m_isr[ml] = 1'b0;
                     if (wr_data[7:5] == 3'd5) m_pb = (ml + 1) % 8;
                  end
               end
               3'd3: m_isr[wr_data[2:0]] = 1'b0;
               3'd6: m_pb = (wr_data[2:0] + 1) % 8;
               3'd7: begin
                  m_isr[wr_data[2:0]] = 1'b0;
                  m_pb = (wr_data[2:0] + 1) % 8;
               end
               default: ;
            endcase
         end
         if (ack_en && mw >= 0) begin
            if (m_aeoi) begin
               if (m_rot) m_pb = (mw + 1) % 8;
            end else m_isr[mw] = 1'b1;
            m_irr[mw] = 1'b0;
         end
         if (rd_en && m_poll) begin
            if (mw >= 0) begin m_irr[mw] = 1'b0; m_isr[mw] = 1'b0; end
            m_poll = 0;
         end
         if (initw) begin m_irr = 0; m_prev = 0; end
         else begin m_irr = m_irr | edges; m_prev = req_in; end
      end
   end

   task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", what, got, exp);
      end
   endtask

   // compare against the reference on every cycle, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int w;
         w = m_win();
         chk({tag, " int_out"}, {7'd0, int_out}, {7'd0, (w >= 0)});
         if (rd_en)
            chk({tag, " rd_data"}, rd_data,
                m_poll ? ((w >= 0) ? 8'(w) : 8'd7) : (addr ? m_imr : (m_rsel ? m_isr : m_irr)));
         if (ack_en)
            chk({tag, " ack_vec"}, ack_vec, m_base | ((w >= 0) ? 8'(w) : 8'd7));
      end
   end

   task automatic wr(bit a, logic [7:0] d, string t);
      @(posedge clk); #1; tag = t; wr_en = 1; addr = a; wr_data = d;
      @(posedge clk); #1; wr_en = 0;
   endtask

   task automatic rd(bit a, string t);
      @(posedge clk); #1; tag = t; rd_en = 1; addr = a;
      @(posedge clk); #1; rd_en = 0;
   endtask

   task automatic ack(string t);
      @(posedge clk); #1; tag = t; ack_en = 1;
      @(posedge clk); #1; ack_en = 0;
   endtask

   task automatic setreq(logic [7:0] v, string t);
      @(posedge clk); #1; tag = t; req_in = v;
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #3 chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
      rd(1, "R1 mask after reset");
      rd(0, "R1 request after reset");
      wr(0, 8'h0B, "R6 select in-service");
      rd(0, "R1 in-service after reset");

      // full four-word setup, base 0x48
      wr(0, 8'h11, "R2 start setup");
      wr(1, 8'h4D, "R3 vector base");
      wr(1, 8'h00, "R3 cascade word");
      wr(1, 8'h00, "R4 option word");
      wr(0, 8'h0A, "R6 select request");

      setreq(8'h08, "R13 raise line 3");
      rd(0, "R13 edge latched");
      ack("R11 vector line 3");
      rd(0, "R13 held line not relatched");
      wr(0, 8'h0B, "R6 select in-service");
      rd(0, "R11 in-service set");

      setreq(8'h2A, "R7 raise lines 1 and 5");
      ack("R7 line 1 beats in-service 3");
      wr(0, 8'h20, "R8 non-specific eoi");
      rd(0, "R8 in-service after first eoi");
      wr(0, 8'h20, "R8 non-specific eoi");
      rd(0, "R8 in-service after second eoi");

      wr(1, 8'h20, "R5 mask line 5");
      rd(1, "R5 mask readback");
      #3 chk("R5 masked line not offered", {7'd0, int_out}, 8'h00);
      wr(1, 8'h00, "R5 unmask");

      wr(0, 8'hC4, "R9 set rotation base");
      wr(0, 8'h40, "R9 code 2 does nothing");
      rd(0, "R9 in-service after no-op");
      ack("R9 rotated winner line 5");
      setreq(8'h00, "R13 drop");
      setreq(8'h0F, "R9 raise lines 0-3");
      #3 chk("R9 blocked by line 5", {7'd0, int_out}, 8'h00);
      wr(0, 8'hE5, "R9 named eoi with rotation");
      ack("R9 winner after rotation");
      wr(0, 8'h60, "R9 named eoi line 0");
      rd(0, "R9 in-service after named eoi");

      wr(0, 8'h0C, "R12 arm poll");
      rd(0, "R12 poll result");
      rd(0, "R12 poll disarmed");
      wr(0, 8'h0A, "R6 select request");
      rd(0, "R12 request cleared by poll");

      ack("R8 take line 2");
      wr(0, 8'hA0, "R8 rotating eoi");
      ack("R8 winner after rotating eoi");
      ack("R11 spurious vector");
      wr(0, 8'h0C, "R12 arm poll");
      rd(0, "R12 spurious poll");

      setreq(8'h00, "R6 drop");
      setreq(8'h20, "R6 raise line 5");
      wr(1, 8'h08, "R6 mask in-service line 3");
      wr(0, 8'h68, "R6 special mask on");
      #3 chk("R6 special mask offers line 5", {7'd0, int_out}, 8'h01);
      ack("R6 special mask vector");
      wr(0, 8'h48, "R6 special mask off");
      wr(1, 8'h00, "R5 unmask");

      // single controller, fourth word, automatic end-of-service
      setreq(8'h00, "R10 drop");
      wr(0, 8'h13, "R2 single setup");
      wr(1, 8'h20, "R3 base skips cascade word");
      wr(1, 8'h02, "R4 auto eoi on");
      wr(0, 8'h80, "R10 rotate on auto eoi");
      setreq(8'h44, "R10 raise lines 2 and 6");
      ack("R10 auto eoi line 2");
      wr(0, 8'h0B, "R6 select in-service");
      rd(0, "R10 in-service stays clear");
      ack("R10 rotated to line 6");
      wr(0, 8'h00, "R10 rotate off");
      setreq(8'h00, "R10 drop");
      setreq(8'h01, "R10 raise line 0");
      ack("R10 plain auto eoi");
      rd(0, "R10 in-service still clear");

      // short single setup without fourth word
      wr(0, 8'h12, "R2 short setup");
      wr(1, 8'h30, "R3 base word ends setup");
      wr(1, 8'hFF, "R3 next word is mask");
      rd(1, "R3 mask after short setup");

      // setup drops the output
      wr(1, 8'h00, "R5 unmask");
      setreq(8'h10, "R2 raise line 4");
      wr(0, 8'h11, "R2 restart setup");
      #3 chk("R2 int_out dropped", {7'd0, int_out}, 8'h00);
      setreq(8'h00, "R14 drop");
      wr(1, 8'h08, "R3 base");
      wr(1, 8'h00, "R3 cascade word");
      wr(1, 8'h10, "R4 nested on");
      setreq(8'h04, "R14 raise line 2");
      ack("R14 take line 2");
      setreq(8'h00, "R14 drop");
      setreq(8'h04, "R14 raise line 2 again");
      #3 chk("R14 nested re-entry offered", {7'd0, int_out}, 8'h01);

      setreq(8'h00, "R4 drop");
      wr(0, 8'h11, "R2 restart setup");
      wr(1, 8'h08, "R3 base");
      wr(1, 8'h00, "R3 cascade word");
      wr(1, 8'h00, "R4 nested off");
      setreq(8'h04, "R4 raise line 2");
      ack("R4 take line 2");
      setreq(8'h00, "R4 drop");
      setreq(8'h04, "R4 raise line 2 again");
      #3 chk("R4 re-entry blocked without nesting", {7'd0, int_out}, 8'h00);

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule